// File: doc/BRIEF.md
# Stereo De-Emphasis Shelving Filter

This block takes a stream of signed 24-bit stereo samples and applies the standard de-emphasis response: unity gain at low frequencies, falling through corners set by 50 µs and 15 µs time constants (about 3.18 kHz and 10.6 kHz), to a high-frequency shelf about 10 dB down. Each channel runs a first-order IIR section. The section's three fixed-point coefficients come from a constant set selected by a 2-bit rate code. The three sets are derived at elaboration by the bilinear transform of the analogue shelf at 44.1 kHz, 48 kHz and 32 kHz.

The filter is bypassed when the rate code is zero or when the speed-mode input is anything other than single-speed. A controller state machine follows the two mode inputs. It has two states. `ST_PASS` forwards samples unchanged. `ST_SHELF` filters them. The transition `GO_SHELF` (PASS to SHELF) occurs when the code becomes non-zero while the speed mode is single-speed. The transition `GO_PASS` (SHELF to PASS) occurs on code zero or a non-single speed mode. The transition `RETUNE` (SHELF to SHELF) occurs on a change of the rate code between non-zero values. Any change of either mode input also clears the filter history of both channels.

Top module: `deemph_shelf`

## Requirements
- R1: While reset is asserted, `out_vld` is 0 and both output samples are 0.
- R2: `out_vld` is high exactly two clock cycles after a cycle in which `in_vld` was high, and low otherwise. This holds in both bypass and filtering.
- R3: When `rate_code` is 00, each output sample equals the corresponding input sample.
- R4: When `speed_mode` is not 00 (00 = single-speed), each output sample equals the input sample, whatever the rate code.
- R5: Rate codes 01, 10 and 11 select coefficients for 44.1 kHz, 48 kHz and 32 kHz respectively. The coefficients are computed with K = 2·fs as b0 = (1+K·15µs)/(1+K·50µs), b1 = (1−K·15µs)/(1+K·50µs) and a1 = (1−K·50µs)/(1+K·50µs). Each is scaled by 2^22 and rounded half away from zero into a signed 24-bit value.
- R6: When filtering, each channel computes acc = b0·x[n] + b1·x[n−1] − a1·y[n−1] at full precision. The output is (acc + 2^21) shifted arithmetically right by 22. Here y[n−1] is the previous filtered output of that channel.
- R7: The filtered result is limited to the range −8388608 to 8388607.
- R8: A change of `rate_code` or `speed_mode` clears x[n−1] and y[n−1] of both channels to zero. A sample accepted in the same cycle as the change is processed with the new settings and zero history.
- R9: The left and right channels keep separate history, so a sample on one channel does not affect the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input stereo sample strobe |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| rate_code | input | 2 | 00 off, 01 44.1 kHz, 10 48 kHz, 11 32 kHz |
| speed_mode | input | 2 | 00 single-speed; other values force bypass |
| out_vld | output | 1 | Output stereo sample strobe |
| out_l | output | 24 | Left output sample, signed |
| out_r | output | 24 | Right output sample, signed |

## Verification
A mode change and an accepted sample can land in the same cycle. The history clear then has to win over the recurrence, and the new coefficient set must already apply to that sample. The bench provokes this case with directed steps that change the rate code or speed mode together with an input strobe, after a run that has left non-zero history. It also provokes it at random by changing the modes on arbitrary cycles of a dense random sample stream. Every output is judged against a bench model that computes its coefficients from the time constants and resets its history on any mode change before it processes the sample of that cycle.

// File: rtl/deemph_pkg.sv
package deemph_pkg;

    localparam int SAMPLE_W = 24;
    localparam int COEF_W   = 24;
    localparam int COEF_FRAC = 22;

    typedef logic signed [COEF_W-1:0] coef_w_t;

    typedef struct packed {
        coef_w_t b0;
        coef_w_t b1;
        coef_w_t a1;
    } coef_set_t;

    typedef enum logic [1:0] {
        RATE_OFF  = 2'b00,
        RATE_44K1 = 2'b01,
        RATE_48K  = 2'b10,
        RATE_32K  = 2'b11
    } rate_code_t;

    localparam logic [1:0] SPEED_SINGLE = 2'b00;

    localparam real TAU_POLE = 50.0e-6;
    localparam real TAU_ZERO = 15.0e-6;

    function automatic coef_w_t to_fixed(input real v);
        real scaled;
        int  ival;
        scaled = v * real'(64'd1 << COEF_FRAC);
        if (scaled >= 0.0) begin
            ival = $rtoi(scaled + 0.5);
        end else begin
            ival = -$rtoi(0.5 - scaled);
        end
        return coef_w_t'(ival);
    endfunction

    function automatic coef_set_t shelf_coefs(input real fs);
        real k;
        real den;
        coef_set_t c;
        k     = 2.0 * fs;
        den   = 1.0 + k * TAU_POLE;
        c.b0  = to_fixed((1.0 + k * TAU_ZERO) / den);
        c.b1  = to_fixed((1.0 - k * TAU_ZERO) / den);
        c.a1  = to_fixed((1.0 - k * TAU_POLE) / den);
        return c;
    endfunction

    localparam coef_set_t COEF_44K1 = shelf_coefs(44100.0);
    localparam coef_set_t COEF_48K  = shelf_coefs(48000.0);
    localparam coef_set_t COEF_32K  = shelf_coefs(32000.0);

endpackage

// File: rtl/deemph_ctrl.sv
module deemph_ctrl
    import deemph_pkg::*;
#(
    parameter int SW  = SAMPLE_W,
    parameter int NCH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [NCH*SW-1:0]    in_data,
    input  logic [1:0]           rate_code,
    input  logic [1:0]           speed_mode,
    output logic                 s1_vld,
    output logic [NCH*SW-1:0]    s1_data,
    output logic                 s1_clr,
    output logic                 s1_shelf,
    output rate_code_t           s1_rate
);

    typedef enum logic [1:0] {
        ST_PASS  = 2'b01,
        ST_SHELF = 2'b10
    } mode_state_t;

    mode_state_t state_q, state_d;
    logic [1:0]  code_q;
    logic [1:0]  speed_q;
    logic        mode_chg;
    logic        want_shelf;

    assign mode_chg   = (rate_code != code_q) || (speed_mode != speed_q);
    assign want_shelf = (rate_code != RATE_OFF) && (speed_mode == SPEED_SINGLE);

    // next-state selection: GO_SHELF, GO_PASS, RETUNE (stay, history cleared)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: begin
                if (want_shelf) begin
                    state_d = ST_SHELF;
                end
            end
            ST_SHELF: begin
                if (!want_shelf) begin
                    state_d = ST_PASS;
                end
            end
            default: state_d = ST_PASS;
        endcase
    end

    // state register and mode history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            code_q  <= RATE_OFF;
            speed_q <= SPEED_SINGLE;
        end else begin
            state_q <= state_d;
            code_q  <= rate_code;
            speed_q <= speed_mode;
        end
    end

    // stage-1 output register, tagged with the mode that applies to it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_data  <= '0;
            s1_clr   <= 1'b0;
            s1_shelf <= 1'b0;
            s1_rate  <= RATE_OFF;
        end else begin
            s1_vld   <= in_vld;
            s1_clr   <= mode_chg;
            s1_shelf <= (state_d == ST_SHELF);
            s1_rate  <= rate_code_t'(rate_code);
            if (in_vld) begin
                s1_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/deemph_coef_sel.sv
module deemph_coef_sel
    import deemph_pkg::*;
(
    input  rate_code_t rate,
    output coef_set_t  coef
);

    always_comb begin
        unique case (rate)
            RATE_44K1: coef = COEF_44K1;
            RATE_48K:  coef = COEF_48K;
            RATE_32K:  coef = COEF_32K;
            default:   coef = COEF_44K1;
        endcase
    end

endmodule

// File: rtl/deemph_chan.sv
module deemph_chan
    import deemph_pkg::*;
#(
    parameter int SW   = SAMPLE_W,
    parameter int CW   = COEF_W,
    parameter int FRAC = COEF_FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_vld,
    input  logic                 s_clr,
    input  logic                 s_shelf,
    input  logic signed [SW-1:0] s_x,
    input  coef_set_t            coef,
    output logic signed [SW-1:0] y_out
);

    localparam int PW = SW + CW;
    localparam int AW = PW + 2;
    localparam logic signed [AW-1:0] Y_MAX = AW'((64'sd1 <<< (SW-1)) - 1);
    localparam logic signed [AW-1:0] Y_MIN = -AW'(64'sd1 <<< (SW-1));
    localparam logic signed [AW-1:0] HALF  = AW'(64'sd1 <<< (FRAC-1));

    logic signed [SW-1:0] x1_q, y1_q;
    logic signed [SW-1:0] x1_e, y1_e;
    logic signed [CW-1:0] cb0, cb1, ca1;
    logic signed [PW-1:0] p0, p1, p2;
    logic signed [AW-1:0] acc, rnd, shr;
    logic signed [SW-1:0] y_sat;
    logic signed [SW-1:0] y_new;

    always_comb begin
        cb0  = coef.b0;
        cb1  = coef.b1;
        ca1  = coef.a1;
        x1_e = s_clr ? '0 : x1_q;
        y1_e = s_clr ? '0 : y1_q;
        p0   = s_x  * cb0;
        p1   = x1_e * cb1;
        p2   = y1_e * ca1;
        acc  = AW'(p0) + AW'(p1) - AW'(p2);
        rnd  = acc + HALF;
        shr  = rnd >>> FRAC;
        if (shr > Y_MAX) begin
            y_sat = Y_MAX[SW-1:0];
        end else if (shr < Y_MIN) begin
            y_sat = Y_MIN[SW-1:0];
        end else begin
            y_sat = shr[SW-1:0];
        end
        y_new = s_shelf ? y_sat : s_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x1_q  <= '0;
            y1_q  <= '0;
            y_out <= '0;
        end else if (s_vld) begin
            x1_q  <= s_x;
            y1_q  <= y_sat;
            y_out <= y_new;
        end else if (s_clr) begin
            x1_q  <= '0;
            y1_q  <= '0;
        end
    end

endmodule

// File: rtl/deemph_shelf.sv
module deemph_shelf
    import deemph_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [SW-1:0] in_l,
    input  logic [SW-1:0] in_r,
    input  logic [1:0]    rate_code,
    input  logic [1:0]    speed_mode,
    output logic          out_vld,
    output logic [SW-1:0] out_l,
    output logic [SW-1:0] out_r
);

    localparam int NCH = 2;

    logic [NCH*SW-1:0] in_bus;
    logic [NCH*SW-1:0] s1_bus;
    logic [NCH*SW-1:0] y_bus;
    logic              s1_vld, s1_clr, s1_shelf;
    rate_code_t        s1_rate;
    coef_set_t         coef;

    assign in_bus = {in_r, in_l};

    deemph_ctrl #(.SW(SW), .NCH(NCH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (in_vld),
        .in_data    (in_bus),
        .rate_code  (rate_code),
        .speed_mode (speed_mode),
        .s1_vld     (s1_vld),
        .s1_data    (s1_bus),
        .s1_clr     (s1_clr),
        .s1_shelf   (s1_shelf),
        .s1_rate    (s1_rate)
    );

    deemph_coef_sel u_coef (
        .rate (s1_rate),
        .coef (coef)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic signed [SW-1:0] ch_y;
        deemph_chan #(.SW(SW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_vld   (s1_vld),
            .s_clr   (s1_clr),
            .s_shelf (s1_shelf),
            .s_x     (s1_bus[ch*SW +: SW]),
            .coef    (coef),
            .y_out   (ch_y)
        );
        assign y_bus[ch*SW +: SW] = ch_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= s1_vld;
        end
    end

    assign out_l = y_bus[0 +: SW];
    assign out_r = y_bus[SW +: SW];

endmodule

// File: rtl/deemph_chk.sv
module deemph_chk #(
    parameter int SW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic [SW-1:0] in_l,
    input logic [SW-1:0] in_r,
    input logic [1:0]    rate_code,
    input logic [1:0]    speed_mode,
    input logic          out_vld,
    input logic [SW-1:0] out_l,
    input logic [SW-1:0] out_r
);

    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_l == '0 && out_r == '0));

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (out_vld == $past(in_vld, 2)));

    a_r3_code_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && $past(in_vld, 2) && $past(rate_code, 2) == 2'b00)
        |-> (out_l == $past(in_l, 2) && out_r == $past(in_r, 2)));

    a_r4_speed_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && $past(in_vld, 2) && $past(speed_mode, 2) != 2'b00)
        |-> (out_l == $past(in_l, 2) && out_r == $past(in_r, 2)));

    a_r8_fresh_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(in_vld, 2) && $past(in_l, 2) == '0 &&
         ($past(rate_code, 2) != $past(rate_code, 3) ||
          $past(speed_mode, 2) != $past(speed_mode, 3)))
        |-> (out_l == '0));

endmodule

bind deemph_shelf deemph_chk #(.SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .in_l       (in_l),
    .in_r       (in_r),
    .rate_code  (rate_code),
    .speed_mode (speed_mode),
    .out_vld    (out_vld),
    .out_l      (out_l),
    .out_r      (out_r)
);

// File: tb/deemph_shelf_bench.sv
module deemph_shelf_bench;

    localparam int SW = 24;
    localparam longint YMAX = 64'sd8388607;
    localparam longint YMIN = -64'sd8388608;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [SW-1:0] in_l = '0;
    logic [SW-1:0] in_r = '0;
    logic [1:0]    rate_code = 2'b00;
    logic [1:0]    speed_mode = 2'b00;
    logic          out_vld;
    logic [SW-1:0] out_l;
    logic [SW-1:0] out_r;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    deemph_shelf #(.SW(SW)) u_deemph_shelf (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_l(in_l), .in_r(in_r),
        .rate_code(rate_code), .speed_mode(speed_mode),
        .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
    );

    // model coefficients (R5)
    longint cb0[4], cb1[4], ca1[4];
    longint hx[2], hy[2];
    logic [1:0] pcode = 2'b00, pspd = 2'b00;

    // expectation pipeline
    logic   e1_v = 0, e2_v = 0;
    longint e1_l = 0, e1_r = 0, e2_l = 0, e2_r = 0;
    string  e1_t = "R2", e2_t = "R2";

    function automatic longint qfix(input real v);
        real s;
        s = v * 4194304.0;
        if (s >= 0.0) return longint'($rtoi(s + 0.5));
        return -longint'($rtoi(0.5 - s));
    endfunction

    function automatic void set_rate(input int idx, input real fs);
        real k, d;
        k = 2.0 * fs;
        d = 1.0 + k * 50.0e-6;
        cb0[idx] = qfix((1.0 + k * 15.0e-6) / d);
        cb1[idx] = qfix((1.0 - k * 15.0e-6) / d);
        ca1[idx] = qfix((1.0 - k * 50.0e-6) / d);
    endfunction

    function automatic longint sx(input logic [SW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint filt(input int ch, input longint x, input int c);
        longint acc, y;
        acc = cb0[c] * x + cb1[c] * hx[ch] - ca1[c] * hy[ch];
        y = (acc + 64'sd2097152) >>> 22;
        if (y > YMAX) y = YMAX;
        if (y < YMIN) y = YMIN;
        return y;
    endfunction

    task automatic check(input string tag, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // one clock: check outputs of the sample driven two cycles ago, then drive
    task automatic tick(input logic v, input longint l, input longint r,
                        input logic [1:0] code, input logic [1:0] spd);
        longint yl, yr, xs[2];
        bit bypass;
        string tg;
        @(negedge clk);
        check("R2", longint'(out_vld), longint'(e2_v));
        if (e2_v) begin
            check(e2_t, sx(out_l), e2_l);
            check({e2_t, "/R9"}, sx(out_r), e2_r);
        end
        e2_v = e1_v; e2_l = e1_l; e2_r = e1_r; e2_t = e1_t;
        in_vld = v; in_l = SW'(l); in_r = SW'(r);
        rate_code = code; speed_mode = spd;
        if (code != pcode || spd != pspd) begin
            hx[0] = 0; hx[1] = 0; hy[0] = 0; hy[1] = 0;
            tg = "R8";
        end else if (spd != 2'b00) tg = "R4";
        else if (code == 2'b00) tg = "R3";
        else tg = "R6";
        pcode = code; pspd = spd;
        bypass = (code == 2'b00) || (spd != 2'b00);
        e1_v = v; e1_t = tg;
        if (v) begin
            xs[0] = sx(SW'(l)); xs[1] = sx(SW'(r));
            yl = filt(0, xs[0], int'(code));
            yr = filt(1, xs[1], int'(code));
            hx[0] = xs[0]; hx[1] = xs[1]; hy[0] = yl; hy[1] = yr;
            e1_l = bypass ? xs[0] : yl;
            e1_r = bypass ? xs[1] : yr;
        end
    endtask

    function automatic longint rnd_sample();
        int sel;
        sel = int'($urandom_range(0, 9));
        if (sel == 0) return YMAX;
        if (sel == 1) return YMIN;
        return sx(SW'($urandom));
    endfunction

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0de3_e3f1));
        set_rate(0, 44100.0);
        set_rate(1, 44100.0);
        set_rate(2, 48000.0);
        set_rate(3, 32000.0);
        hx = '{0, 0}; hy = '{0, 0};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", longint'(out_vld), 0);
        check("R1", sx(out_l), 0);
        check("R1", sx(out_r), 0);
        rst_n = 1'b1;

        // R3: code 00 bypass
        tick(1, 12345, -777, 2'b00, 2'b00);
        tick(1, YMAX, YMIN, 2'b00, 2'b00);
        tick(0, 0, 0, 2'b00, 2'b00);

        // R5/R6: impulse on left only, right silent (R9), per rate code
        for (int c = 1; c < 4; c++) begin
            tick(1, 1000000, 0, 2'(c), 2'b00);
            for (int i = 0; i < 6; i++) tick(1, 0, 0, 2'(c), 2'b00);
        end

        // R8: mode change in the same cycle as a sample, after non-zero history
        for (int i = 0; i < 5; i++) tick(1, 3000000, -3000000, 2'b01, 2'b00);
        tick(1, 500000, 500000, 2'b11, 2'b00);
        tick(1, 0, 0, 2'b11, 2'b00);
        for (int i = 0; i < 5; i++) tick(1, 3000000, 2000000, 2'b11, 2'b00);
        tick(0, 0, 0, 2'b10, 2'b00);
        tick(1, 0, 0, 2'b10, 2'b00);

        // R4: non-single speed forces bypass for every code
        for (int c = 0; c < 4; c++) tick(1, -4242 * (c + 1), 999 * c, 2'(c), 2'b01);
        tick(1, 55555, -55555, 2'b10, 2'b10);
        tick(1, 1, -1, 2'b10, 2'b00);

        // R7: sustained full scale and alternating full scale
        for (int i = 0; i < 300; i++) tick(1, YMAX, YMIN, 2'b01, 2'b00);
        for (int i = 0; i < 100; i++)
            tick(1, (i % 2 == 0) ? YMAX : YMIN, (i % 2 == 0) ? YMIN : YMAX, 2'b11, 2'b00);

        // random stream with random mode changes
        begin
            logic [1:0] c, s;
            c = 2'b01; s = 2'b00;
            for (int i = 0; i < 6000; i++) begin
                if ($urandom_range(0, 39) == 0) c = 2'($urandom);
                if ($urandom_range(0, 79) == 0) s = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
                tick(($urandom_range(0, 3) != 0), rnd_sample(), rnd_sample(), c, s);
            end
        end

        tick(0, 0, 0, 2'b00, 2'b00);
        tick(0, 0, 0, 2'b00, 2'b00);
        tick(0, 0, 0, 2'b00, 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule